// File: doc/BRIEF.md
# Staged Reset-Release Sequencer with Bounded Retry

This block brings a graphics processor and a host processor out of reset in a fixed order once the platform reports that power and clocks are good. It first lets the graphics processor run and waits for it to report reset completion. It then waits for the interconnect link to reach its active (L0) state, releases the host processor, and waits for a single handshake pulse from host software. Each of the three waits has its own cycle-count timeout.

When any wait times out, both resets are pulled back for a programmable hold period and the whole sequence restarts from the graphics release. At most four such restarts happen, so five attempts in total. If the fifth attempt also times out, the block parks in a terminal failure state. In that state both resets stay asserted and it reports an error code and a four-digit display code naming the stage that failed. Transient failures that are later retried are visible only on a retry status output and an attempt counter.

Top module: `boot_seq`

## Requirements
- R1: After reset, and while `pwr_good_i` is low in the idle state, both reset outputs are low (asserted), `boot_ok_o`, `boot_err_o` and `retry_o` are 0, `err_code_o` and `disp_code_o` are 0, and `attempt_o` is 1.
- R2: In the idle state, `pwr_good_i` high at a clock edge raises `gfx_rst_no` from that edge on, while `host_rst_no` stays low. The host reset is never released while the graphics reset is asserted.
- R3: While waiting for `rst_done_i`, the graphics reset stays released for at most RST_TMO cycles. A `rst_done_i` seen in the last of those cycles is still accepted and no retry follows.
- R4: When `link_l0_i` is seen in the link wait, `host_rst_no` goes high at that edge. Without it, the link wait times out after L0_TMO cycles.
- R5: A `handshake_i` pulse in the host wait makes `boot_ok_o` go high at that edge. It then stays high, with both resets released, until reset. Without the pulse, the host wait times out after HS_TMO cycles with the host reset released.
- R6: A timeout that is not on the final attempt drives both resets low and `retry_o` high for exactly HOLD_CYC cycles. The graphics reset is then released again.
- R7: A timeout on the fifth attempt sets `boot_err_o` permanently, with both resets low. From then on, the inputs have no effect on any output until reset.
- R8: In the terminal state, `err_code_o`/`disp_code_o` are 0x08/0x0020 for a reset-done timeout, 0x09/0x0021 for a link timeout and 0x0A/0x0022 for a handshake timeout. The display code is four hex digits. In every other state both codes are 0.
- R9: `attempt_o` counts from 1 and rises by one on each retry, reaching 5 at most. A later successful boot keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Power and clocks of the graphics processor are good |
| rst_done_i | input | 1 | Graphics processor reports reset completion |
| link_l0_i | input | 1 | Link status is L0 |
| handshake_i | input | 1 | Handshake pulse from host software |
| gfx_rst_no | output | 1 | Graphics processor reset, active low |
| host_rst_no | output | 1 | Host processor reset, active low |
| boot_ok_o | output | 1 | Sequence finished successfully |
| boot_err_o | output | 1 | Terminal boot error class flag |
| retry_o | output | 1 | Retry hold after a transient timeout |
| attempt_o | output | 3 | Current attempt number, 1 to 5 |
| err_code_o | output | 8 | Terminal error code |
| disp_code_o | output | 16 | Terminal display code, four hex digits |

## Verification
Every result is registered state decoded directly to outputs, so an input that is sampled at a clock edge shows its effect on the outputs right after that same edge. The bench drives inputs on the falling edge and samples at the next falling edge, which is exactly one edge later. Timeouts are checked by counting the falling edges during which an output holds its level, and comparing the count with the stage's limit: RST_TMO, 1+L0_TMO, 2+HS_TMO or HOLD_CYC. This catches off-by-one errors in either direction. The last-cycle acceptance case drives `rst_done_i` exactly RST_TMO-1 falling edges after the release was observed.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GFX,
    ST_LINK,
    ST_HOST,
    ST_OK,
    ST_HOLD,
    ST_FAIL
  } stage_e;

  localparam logic [7:0] CODE_NONE     = 8'h00;
  localparam logic [7:0] CODE_RST_DONE = 8'h08;
  localparam logic [7:0] CODE_NO_LINK  = 8'h09;
  localparam logic [7:0] CODE_NO_HS    = 8'h0A;

  // error code of the wait stage that timed out
  function automatic logic [7:0] code_of_stage(stage_e s);
    case (s)
      ST_GFX:  return CODE_RST_DONE;
      ST_LINK: return CODE_NO_LINK;
      ST_HOST: return CODE_NO_HS;
      default: return CODE_NONE;
    endcase
  endfunction

  // display digits "002x" where x = code - 8
  function automatic logic [15:0] disp_of_code(logic [7:0] c);
    logic [3:0] low;
    low = c[3:0] - 4'd8;
    if (c == CODE_NONE) return 16'h0000;
    return {8'h00, 4'h2, low};
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/boot_seq_timer.sv
module boot_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
  end

  // final cycle of a window of limit_i cycles
  assign last_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int RST_TMO  = 1000,
  parameter int L0_TMO   = 2000,
  parameter int HS_TMO   = 50000,
  parameter int HOLD_CYC = 100,
  parameter int RETRIES  = 4,
  parameter int CNT_W    = 16,
  parameter int ATT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             rst_done_i,
  input  logic             link_l0_i,
  input  logic             handshake_i,
  input  logic             tmr_last_i,
  output logic             tmr_clear_o,
  output logic [CNT_W-1:0] tmr_limit_o,
  output stage_e           stage_o,
  output logic [ATT_W-1:0] attempt_o,
  output logic [7:0]       code_o,
  output logic             tmo_evt_o
);
  localparam int ATTEMPTS = RETRIES + 1;

  stage_e           stage_q, stage_d;
  logic [ATT_W-1:0] attempt_q;
  logic [7:0]       code_q;
  logic             final_att;

  function automatic logic [CNT_W-1:0] limit_of(stage_e s);
    case (s)
      ST_GFX:  return CNT_W'(RST_TMO);
      ST_LINK: return CNT_W'(L0_TMO);
      ST_HOST: return CNT_W'(HS_TMO);
      default: return CNT_W'(HOLD_CYC);
    endcase
  endfunction

  assign final_att = (attempt_q == ATT_W'(ATTEMPTS));

  always_comb begin
    stage_d   = stage_q;
    tmo_evt_o = 1'b0;
    case (stage_q)
      ST_IDLE: if (pwr_good_i) stage_d = ST_GFX;
      ST_GFX:  if (rst_done_i) stage_d = ST_LINK;
               else if (tmr_last_i) tmo_evt_o = 1'b1;
      ST_LINK: if (link_l0_i) stage_d = ST_HOST;
               else if (tmr_last_i) tmo_evt_o = 1'b1;
      ST_HOST: if (handshake_i) stage_d = ST_OK;
               else if (tmr_last_i) tmo_evt_o = 1'b1;
      ST_HOLD: if (tmr_last_i) stage_d = ST_GFX;
      default: stage_d = stage_q;
    endcase
    if (tmo_evt_o) stage_d = final_att ? ST_FAIL : ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= ST_IDLE;
      attempt_q <= ATT_W'(1);
      code_q    <= CODE_NONE;
    end else begin
      stage_q <= stage_d;
      if (tmo_evt_o && !final_att) attempt_q <= attempt_q + 1'b1;
      if (tmo_evt_o && final_att)  code_q    <= code_of_stage(stage_q);
    end
  end

  assign tmr_clear_o = (stage_d != stage_q);
  assign tmr_limit_o = limit_of(stage_q);
  assign stage_o     = stage_q;
  assign attempt_o   = attempt_q;
  assign code_o      = code_q;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int RST_TMO  = 1000,
  parameter int L0_TMO   = 2000,
  parameter int HS_TMO   = 50000,
  parameter int HOLD_CYC = 100,
  parameter int RETRIES  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_good_i,
  input  logic        rst_done_i,
  input  logic        link_l0_i,
  input  logic        handshake_i,
  output logic        gfx_rst_no,
  output logic        host_rst_no,
  output logic        boot_ok_o,
  output logic        boot_err_o,
  output logic        retry_o,
  output logic [2:0]  attempt_o,
  output logic [7:0]  err_code_o,
  output logic [15:0] disp_code_o
);
  localparam int MAX_LIM = max3(max3(RST_TMO, L0_TMO, HS_TMO), HOLD_CYC, 1);
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam int ATT_W   = 3;

  logic             tmr_clear, tmr_last, tmo_evt;
  logic [CNT_W-1:0] tmr_limit;
  stage_e           stage;
  logic [ATT_W-1:0] attempt;
  logic [7:0]       code;

  boot_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .limit_i (tmr_limit),
    .last_o  (tmr_last)
  );

  boot_seq_fsm #(
    .RST_TMO (RST_TMO), .L0_TMO (L0_TMO), .HS_TMO (HS_TMO),
    .HOLD_CYC(HOLD_CYC), .RETRIES(RETRIES), .CNT_W(CNT_W), .ATT_W(ATT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .rst_done_i  (rst_done_i),
    .link_l0_i   (link_l0_i),
    .handshake_i (handshake_i),
    .tmr_last_i  (tmr_last),
    .tmr_clear_o (tmr_clear),
    .tmr_limit_o (tmr_limit),
    .stage_o     (stage),
    .attempt_o   (attempt),
    .code_o      (code),
    .tmo_evt_o   (tmo_evt)
  );

  assign gfx_rst_no  = (stage inside {ST_GFX, ST_LINK, ST_HOST, ST_OK});
  assign host_rst_no = (stage inside {ST_HOST, ST_OK});
  assign boot_ok_o   = (stage == ST_OK);
  assign boot_err_o  = (stage == ST_FAIL);
  assign retry_o     = (stage == ST_HOLD);
  assign attempt_o   = attempt;
  assign err_code_o  = code;
  assign disp_code_o = disp_of_code(code);
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ATTEMPTS = 5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        gfx_rst_no,
  input logic        host_rst_no,
  input logic        boot_ok_o,
  input logic        boot_err_o,
  input logic        retry_o,
  input logic [2:0]  attempt_o,
  input logic [7:0]  err_code_o,
  input logic [15:0] disp_code_o,
  input logic        tmo_evt
);
  a_r2_host_after_gfx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gfx_rst_no |-> !host_rst_no);

  a_r5_ok_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_ok_o |=> boot_ok_o && gfx_rst_no && host_rst_no);

  a_r6_hold_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> !gfx_rst_no && !host_rst_no);

  a_r6_tmo_reaction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_evt |=> retry_o || boot_err_o);

  a_r7_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_err_o |=> boot_err_o && $stable(err_code_o));

  a_r7_fail_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_err_o |-> !gfx_rst_no && !host_rst_no && attempt_o == 3'(ATTEMPTS));

  a_r8_code_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_err_o |-> (err_code_o inside {8'h08, 8'h09, 8'h0A}) &&
                   disp_code_o == {12'h002, err_code_o[3:0] - 4'd8});

  a_r8_code_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_err_o |-> err_code_o == 8'h00 && disp_code_o == 16'h0000);

  a_r9_attempt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempt_o >= 3'd1 && attempt_o <= 3'(ATTEMPTS));

  a_r9_attempt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempt_o == $past(attempt_o) || attempt_o == $past(attempt_o) + 3'd1);
endmodule

bind boot_seq boot_seq_chk #(.ATTEMPTS(RETRIES + 1)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gfx_rst_no  (gfx_rst_no),
  .host_rst_no (host_rst_no),
  .boot_ok_o   (boot_ok_o),
  .boot_err_o  (boot_err_o),
  .retry_o     (retry_o),
  .attempt_o   (attempt_o),
  .err_code_o  (err_code_o),
  .disp_code_o (disp_code_o),
  .tmo_evt     (tmo_evt)
);

// File: tb/boot_seq_bench.sv
module boot_seq_bench;
  localparam int RST_TMO  = 10;
  localparam int L0_TMO   = 12;
  localparam int HS_TMO   = 14;
  localparam int HOLD_CYC = 5;
  localparam int RETRIES  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr, rdone, link, hs;
  logic gfx_n, host_n, ok, err, retry;
  logic [2:0]  att;
  logic [7:0]  code;
  logic [15:0] disp;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  boot_seq #(.RST_TMO(RST_TMO), .L0_TMO(L0_TMO), .HS_TMO(HS_TMO),
             .HOLD_CYC(HOLD_CYC), .RETRIES(RETRIES)) u_boot_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .rst_done_i(rdone),
    .link_l0_i(link), .handshake_i(hs), .gfx_rst_no(gfx_n), .host_rst_no(host_n),
    .boot_ok_o(ok), .boot_err_o(err), .retry_o(retry), .attempt_o(att),
    .err_code_o(code), .disp_code_o(disp)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwr = 0; rdone = 0; link = 0; hs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // count negedges during which sig stays at lvl
  task automatic count_level(ref logic sig, input logic lvl, output int n);
    n = 0;
    while (sig === lvl) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "gfx_rst_n", int'(gfx_n), 0);
    chk("R1", "host_rst_n", int'(host_n), 0);
    chk("R1", "ok/err/retry", int'({ok, err, retry}), 0);
    chk("R1", "codes", int'({code, disp}), 0);
    chk("R1", "attempt", int'(att), 1);
    rdone = 1; link = 1; hs = 1;
    repeat (20) @(negedge clk);
    chk("R1", "idle without power", int'({gfx_n, host_n}), 0);
  endtask

  task automatic t_happy();
    do_reset();
    pwr = 1; @(negedge clk);
    chk("R2", "gfx released", int'(gfx_n), 1);
    chk("R2", "host held", int'(host_n), 0);
    rdone = 1; @(negedge clk);
    chk("R4", "host held in link wait", int'(host_n), 0);
    link = 1; @(negedge clk);
    chk("R4", "host released", int'(host_n), 1);
    chk("R5", "not ok before handshake", int'(ok), 0);
    hs = 1; @(negedge clk); hs = 0;
    chk("R5", "boot ok", int'(ok), 1);
    pwr = 0; rdone = 0; link = 0;
    repeat (10) @(negedge clk);
    chk("R5", "ok sticky", int'({ok, gfx_n, host_n}), 7);
    chk("R9", "attempt on clean boot", int'(att), 1);
  endtask

  // stage 0: no reset-done, 1: no link, 2: no handshake
  task automatic t_all_fail(int stage);
    int n, win;
    string rq;
    do_reset();
    rq  = (stage == 0) ? "R3" : (stage == 1) ? "R4" : "R5";
    win = (stage == 0) ? RST_TMO : (stage == 1) ? 1 + L0_TMO : 2 + HS_TMO;
    rdone = (stage >= 1); link = (stage >= 2);
    pwr = 1; @(negedge clk);
    for (int a = 1; a <= RETRIES + 1; a++) begin
      chk("R9", "attempt number", int'(att), a);
      count_level(gfx_n, 1'b1, n);
      chk(rq, "release window", n, win);
      if (a <= RETRIES) begin
        chk("R6", "retry flag", int'(retry), 1);
        chk("R9", "attempt after retry", int'(att), a + 1);
        count_level(retry, 1'b1, n);
        chk("R6", "hold length", n, HOLD_CYC);
      end
    end
    chk("R7", "terminal error", int'(err), 1);
    chk("R8", "error code", int'(code), 8 + stage);
    chk("R8", "display code", int'(disp), 'h20 + stage);
    pwr = 1; rdone = 1; link = 1; hs = 1;
    repeat (30) @(negedge clk);
    hs = 0;
    chk("R7", "still failed, resets held", int'({err, gfx_n, host_n, ok}), 8);
    chk("R7", "code unchanged", int'(code), 8 + stage);
  endtask

  task automatic t_recover();
    do_reset();
    pwr = 1; @(negedge clk);
    while (!(att == 3'd3 && gfx_n)) @(negedge clk);
    rdone = 1; @(negedge clk);
    link = 1; @(negedge clk);
    hs = 1; @(negedge clk); hs = 0;
    chk("R9", "attempt kept on success", int'(att), 3);
    chk("R5", "boot ok after retries", int'({ok, err}), 2);
    chk("R8", "no code after transient errors", int'({code, disp}), 0);
  endtask

  task automatic t_last_cycle();
    do_reset();
    pwr = 1; @(negedge clk);
    repeat (RST_TMO - 1) @(negedge clk);
    rdone = 1; @(negedge clk);
    chk("R3", "accepted in last cycle", int'({gfx_n, retry}), 2);
    link = 1; @(negedge clk);
    chk("R3", "no retry, attempt 1", int'({host_n, att}), 9);
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    pwr = 0; rdone = 0; link = 0; hs = 0;
    t_reset_state();
    t_happy();
    t_all_fail(0);
    t_all_fail(1);
    t_all_fail(2);
    t_recover();
    t_last_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule